// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Lamp Controller

This block drives the red, yellow and green lamps of a crossing where a busy highway meets a quiet farm road. Two state machines on one clock share the work. A sequencer with four phases chooses which road may go. A separate interval timer measures how long a phase has lasted. The highway keeps green by default. The farm road gets a green only when a car waits on it, and it never holds green for longer than the long interval.

The two machines exchange three signals and nothing else. The sequencer sends a one-cycle restart pulse on every phase change. The interval timer then counts up from zero through a chain of count states. It raises a short-interval flag from count SHORT_TICKS onward, and a long-interval flag at count LONG_TICKS. At LONG_TICKS it stops and holds until the next restart. The farm-road car sensor is asynchronous, so it passes through a two-flop synchronizer before the sequencer uses it. The lamp outputs come straight from registers.

Top module: `crossing_ctrl`

## Requirements
- R1: While `rst` is high, and on every cycle after its release until the first phase change, the lamps show highway green with farm red. The interval timer restarts from count 0 on the first rising edge after release.
- R2: The lamp pattern is a pure function of the phase. The phases are highway green, highway yellow, farm green and farm yellow, and each phase lights exactly the matching lamp on its own road and red on the other road.
- R3: Highway green is held for at least 20 cycles after it is entered (count 0 through LONG_TICKS=19). It is also held for as long as no synchronized car is present.
- R4: From highway green, the lamps switch to highway yellow on the edge where the long flag and the synchronized car are both true. Highway yellow lasts exactly 5 cycles, and then farm green follows.
- R5: Farm green ends at the latest after 20 cycles, when the long flag is reached, even while a car is still waiting.
- R6: Farm green ends early on the edge after the synchronized car goes low. Farm yellow lasts exactly 5 cycles, and then highway green follows.
- R7: The car input is sampled by two flops. A change on `car_in` that is set up before rising edge j affects the lamps no earlier than edge j+2.
- R8: Each restart pulse returns the timer to count 0, with both flags low on the next cycle. The short flag is true from count SHORT_TICKS=4. The long flag stays high until the next restart once it has been reached.
- R9: At most one lamp is lit per road, and at least one of the two roads shows red on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both machines |
| rst | input | 1 | Synchronous active-high reset |
| car_in | input | 1 | Asynchronous farm-road car sensor, high while a car waits |
| hwy_red | output | 1 | Highway red lamp |
| hwy_yel | output | 1 | Highway yellow lamp |
| hwy_grn | output | 1 | Highway green lamp |
| farm_red | output | 1 | Farm-road red lamp |
| farm_yel | output | 1 | Farm-road yellow lamp |
| farm_grn | output | 1 | Farm-road green lamp |

## Verification
A phase decision is taken in the same cycle that the timer flag or synchronized car becomes true, and the lamp registers show the new phase right after the next rising edge. A car input change set up before edge j therefore shows up on the lamps only after edge j+2. After reset, highway green with a waiting car leaves on edge 20, each yellow lasts five edges, and an uninterrupted farm green lasts twenty. The driver converts this edge arithmetic into one expected lamp word per edge. The monitor compares each word on the falling edge that follows its rising edge, so no comparison lands on an edge where the lamps are changing.

// File: rtl/crossing_pkg.sv
package crossing_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FARM_GO  = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;

  typedef struct packed {
    lamp_t hwy;
    lamp_t farm;
  } lamp_pair_t;

  localparam lamp_t LAMP_RED = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
  localparam lamp_t LAMP_YEL = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
  localparam lamp_t LAMP_GRN = '{red: 1'b0, yel: 1'b0, grn: 1'b1};

  function automatic lamp_pair_t lamps_for(input phase_t ph);
    lamp_pair_t lp;
    case (ph)
      PH_HWY_GO:    begin lp.hwy = LAMP_GRN; lp.farm = LAMP_RED; end
      PH_HWY_WARN:  begin lp.hwy = LAMP_YEL; lp.farm = LAMP_RED; end
      PH_FARM_GO:   begin lp.hwy = LAMP_RED; lp.farm = LAMP_GRN; end
      default:      begin lp.hwy = LAMP_RED; lp.farm = LAMP_YEL; end
    endcase
    return lp;
  endfunction

endpackage

// File: rtl/crossing_car_sync.sv
module crossing_car_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= 1'b0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/crossing_interval_timer.sv
module crossing_interval_timer #(
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);

  localparam int CNT_W = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_AT = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_AT  = CNT_W'(LONG_TICKS);

  logic [CNT_W-1:0] count_q;

  // Count states T0..T(LONG); the last one is the parking state.
  always_ff @(posedge clk) begin
    if (rst || restart)         count_q <= '0;
    else if (count_q != LONG_AT) count_q <= count_q + 1'b1;
  end

  assign short_done = (count_q >= SHORT_AT);
  assign long_done  = (count_q == LONG_AT);

endmodule

// File: rtl/crossing_sequencer.sv
module crossing_sequencer
  import crossing_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       car_seen,
  input  logic       short_done,
  input  logic       long_done,
  output logic       restart,
  output lamp_pair_t lamps
);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_HWY_GO:    if (long_done && car_seen)  phase_d = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)             phase_d = PH_FARM_GO;
      PH_FARM_GO:   if (long_done || !car_seen) phase_d = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)             phase_d = PH_HWY_GO;
      default:                                  phase_d = PH_HWY_GO;
    endcase
  end

  // Hand-off pulse: one cycle, on the edge that changes the phase.
  assign restart = (phase_d != phase_q) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_HWY_GO;
      lamps   <= lamps_for(PH_HWY_GO);
    end else begin
      phase_q <= phase_d;
      lamps   <= lamps_for(phase_d);
    end
  end

endmodule

// File: rtl/crossing_ctrl.sv
module crossing_ctrl
  import crossing_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic car_in,
  output logic hwy_red,
  output logic hwy_yel,
  output logic hwy_grn,
  output logic farm_red,
  output logic farm_yel,
  output logic farm_grn
);

  logic       car_sync;
  logic       st_pulse;
  logic       ts_flag;
  logic       tl_flag;
  lamp_pair_t lamp_q;

  crossing_car_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (car_in),
    .sync_out (car_sync)
  );

  crossing_interval_timer #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .restart    (st_pulse),
    .short_done (ts_flag),
    .long_done  (tl_flag)
  );

  crossing_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .car_seen   (car_sync),
    .short_done (ts_flag),
    .long_done  (tl_flag),
    .restart    (st_pulse),
    .lamps      (lamp_q)
  );

  assign hwy_red  = lamp_q.hwy.red;
  assign hwy_yel  = lamp_q.hwy.yel;
  assign hwy_grn  = lamp_q.hwy.grn;
  assign farm_red = lamp_q.farm.red;
  assign farm_yel = lamp_q.farm.yel;
  assign farm_grn = lamp_q.farm.grn;

endmodule

// File: rtl/crossing_ctrl_chk.sv
module crossing_ctrl_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic car_raw,
  input logic car_s,
  input logic st,
  input logic ts,
  input logic tl,
  input logic [2:0] hwy,
  input logic [2:0] farm
);

  // R9
  one_lamp_per_road_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(hwy) == 1) && ($countones(farm) == 1));

  // R9
  one_road_red_chk: assert property (@(posedge clk) disable iff (rst)
    hwy[2] || farm[2]);

  // R8
  restart_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
    st |=> (!ts && !tl));

  // R8
  long_flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (tl && !st) |=> tl);

  // R8
  long_implies_short_chk: assert property (@(posedge clk) disable iff (rst)
    tl |-> ts);

  // R2
  restart_moves_lamps_chk: assert property (@(posedge clk) disable iff (rst)
    st |=> !$stable({hwy, farm}));

  // R4
  hwy_yellow_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (hwy[1] && ts) |=> farm[0]);

  // R6
  farm_yellow_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (farm[1] && ts) |=> hwy[0]);

  if (SYNC_STAGES == 2) begin : g_two_stage
    // R7
    car_sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(car_s) |-> $past(car_raw, 2));
  end

endmodule

bind crossing_ctrl crossing_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .car_raw (car_in),
  .car_s   (car_sync),
  .st      (st_pulse),
  .ts      (ts_flag),
  .tl      (tl_flag),
  .hwy     ({hwy_red, hwy_yel, hwy_grn}),
  .farm    ({farm_red, farm_yel, farm_grn})
);

// File: tb/crossing_ctrl_bench.sv
module crossing_ctrl_bench;

  localparam logic [5:0] HG = 6'b001_100;
  localparam logic [5:0] HY = 6'b010_100;
  localparam logic [5:0] FG = 6'b100_001;
  localparam logic [5:0] FY = 6'b100_010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_in = 1'b0;
  logic hwy_red, hwy_yel, hwy_grn, farm_red, farm_yel, farm_grn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  crossing_ctrl u_crossing_ctrl (
    .clk      (clk),
    .rst      (rst),
    .car_in   (car_in),
    .hwy_red  (hwy_red),
    .hwy_yel  (hwy_yel),
    .hwy_grn  (hwy_grn),
    .farm_red (farm_red),
    .farm_yel (farm_yel),
    .farm_grn (farm_grn)
  );

  // One expected lamp word for each of the next n rising edges.
  task automatic expect_edges(input logic [5:0] pat, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      exp_q.push_back(pat);
      tag_q.push_back(tag);
    end
  endtask

  // Monitor: compares away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [5:0] exp_v;
        logic [5:0] got_v;
        string      tg;
        exp_v = exp_q.pop_front();
        tg    = tag_q.pop_front();
        got_v = {hwy_red, hwy_yel, hwy_grn, farm_red, farm_yel, farm_grn};
        checks++;
        if (got_v !== exp_v) begin
          fails++;
          $display("FAIL %s: lamps got %b expected %b at %0t", tg, got_v, exp_v, $time);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    exp_q.push_back(HG); tag_q.push_back("R1 during reset");
    @(posedge clk);
    #1;
    rst = 1'b0;
    expect_edges(HG, 30, "R3 R1 no car after reset");
    car_in = 1'b1;
    expect_edges(HG, 2,  "R7 car not yet synchronized");
    expect_edges(HY, 5,  "R4 R8 highway yellow");
    expect_edges(FG, 20, "R5 R2 farm green to long limit");
    expect_edges(FY, 5,  "R6 R9 farm yellow");
    expect_edges(HG, 20, "R3 minimum highway green");
    expect_edges(HY, 5,  "R4 highway yellow again");
    expect_edges(FG, 5,  "R2 farm green");
    car_in = 1'b0;
    expect_edges(FG, 2,  "R7 car drop in sync chain");
    expect_edges(FY, 5,  "R6 early farm yellow");
    expect_edges(HG, 6,  "R3 highway green no car");
    car_in = 1'b1;
    expect_edges(HG, 14, "R3 car waits for long limit");
    expect_edges(HY, 5,  "R4 R8 highway yellow third");
    expect_edges(FG, 20, "R5 farm green long limit");
    expect_edges(FY, 5,  "R6 farm yellow third");
    expect_edges(HG, 5,  "R2 R9 highway green final");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule